// File: doc/BRIEF.md
# Thermal Limit and Alarm Register Bank

This block is the register file that sits behind a thermal sensor on a byte-wide register bus. It keeps the most recent temperature sample, four programmable thresholds (over, under, over-critical and under-critical), a sticky alarm status byte and a sensor-disable control bit. It also returns fixed identity, revision, vendor and capability bytes. The bus protocol engine in front of it presents one address, a write strobe and a write byte per cycle, and takes the read byte back combinationally from the addressed register.

Each temperature is a signed two's-complement value of `TEMP_W` bits (11 by default) in quarter-degree steps, so the default range runs from -256.00 to +255.75 degrees. In the register space it occupies bits 2 and up of a 16-bit pair, low byte at the lower address. Bits 1:0 and every bit above the value always read zero. When the analog front end strobes a new sample and the sensor is enabled, the sample is stored and compared with the four thresholds. Any alarm it raises stays latched until software writes a mask to the clear register.

Top module: `thermal_regbank`

## Requirements
- R1: After reset the temperature, all four thresholds, the status byte, the disable bit and the mode register are zero.
- R2: Address 0x00 reads 0x51, 0x01 reads 0x18 and 0x05 reads 0x02. The revision byte at 0x02 reads {2'b00, REV_MAJOR[1:0], REV_MINOR[2:0], 1'b0}.
- R3: Vendor bytes at 0x03 (bank) and 0x04 (id) carry the 7-bit parameter in bits 6:0 and, in bit 7, the bit that makes the count of ones in the byte odd.
- R4: The threshold pairs sit at 0x1C/0x1D (over), 0x1E/0x1F (under), 0x20/0x21 (over-critical) and 0x22/0x23 (under-critical). A write to the even byte stores value bits 5:0 from data bits 7:2. A write to the odd byte stores value bits 10:6 from data bits 4:0. Reads return {value[5:0], 2'b00} and {3'b000, value[10:6]}.
- R5: A sample strobed while enabled can be read in the next cycle at 0x31 as {t[5:0], 2'b00} and at 0x32 as {3'b000, t[10:6]}.
- R6: A stored sample sets status bit 0 if it is strictly above the over threshold, bit 1 if strictly below the under threshold, bit 2 if strictly above over-critical and bit 3 if strictly below under-critical. All comparisons are signed. The status byte reads at 0x33 as {4'b0000, bits}.
- R7: A set status bit stays set across later in-range samples until it is cleared.
- R8: A write to 0x13 clears each status bit whose mask bit (data bits 3:0) is one. If a sample sets the same bit in the same cycle, the set wins.
- R9: Reads of 0x13 and 0x14 return zero.
- R10: Bit 0 of 0x1A disables the sensor and the other bits read zero. While it is set, strobed samples change neither the temperature nor the status.
- R11: The mode register at 0x0B stores data bits 3:0. Its bits 7:4 read zero.
- R12: Writes to any address other than 0x0B, 0x13, 0x1A and 0x1C-0x23 change nothing.
- R13: Addresses with no register behind them read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr (combinational) |
| samp_valid | input | 1 | New temperature sample strobe |
| samp_temp | input | TEMP_W | Sample value, two's complement, quarter degrees |

## Verification
Directed samples are placed exactly on each threshold and one step beyond it, to separate a strict comparison from an inclusive one and a signed comparison from an unsigned one. Samples at the extreme codes -1024 and +1023 check the sign handling and the bit placement in the readback pair. Further directed cases cover a clear and a set in the same cycle, a partial clear mask, writes to read-only addresses and samples taken while disabled. Each of these separates one specific misbehaviour from correct operation. A seeded random mix of single threshold byte writes, samples, clears and disable toggles is then checked against a bench model, which exposes wrong byte-to-field mapping and lost or spurious latched bits.

// File: rtl/thr_regbank_pkg.sv
`timescale 1ns/1ps
package thr_regbank_pkg;
   localparam int A_ID0      = 'h00;
   localparam int A_ID1      = 'h01;
   localparam int A_REV      = 'h02;
   localparam int A_VND_BANK = 'h03;
   localparam int A_VND_ID   = 'h04;
   localparam int A_CAP      = 'h05;
   localparam int A_MODE     = 'h0B;
   localparam int A_CLR      = 'h13;
   localparam int A_ERRCLR   = 'h14;
   localparam int A_CFG      = 'h1A;
   localparam int A_LIM_BASE = 'h1C;
   localparam int A_TEMP_LO  = 'h31;
   localparam int A_TEMP_HI  = 'h32;
   localparam int A_STAT     = 'h33;

   localparam int NLIM = 4;
   // limit order: 0 over, 1 under, 2 over-critical, 3 under-critical
   localparam logic [NLIM-1:0] LIM_ABOVE = 4'b0101;

   localparam logic [7:0] ID0_VAL = 8'h51;
   localparam logic [7:0] ID1_VAL = 8'h18;
   localparam logic [7:0] CAP_VAL = 8'h02;

   function automatic logic [7:0] with_odd_parity(input logic [6:0] d);
      return {~(^d), d};
   endfunction
endpackage

// File: rtl/thr_limit_pair.sv
`timescale 1ns/1ps
module thr_limit_pair #(
   parameter int TEMP_W = 11,
   parameter logic [TEMP_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [7:0]        wdata,
   output logic [TEMP_W-1:0] value,
   output logic [7:0]        rd_lo,
   output logic [7:0]        rd_hi
);
   localparam int LO_W = 6;
   localparam int HI_W = TEMP_W - LO_W;

   if (TEMP_W < 7 || TEMP_W > 14) begin : g_bad_width
      $error("thr_limit_pair: TEMP_W must lie in 7..14");
   end

   logic [15:0] word;
   logic        unused_lsbs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= RST_VAL;
      end else begin
         if (wr_lo) value[LO_W-1:0]      <= wdata[7:2];
         if (wr_hi) value[TEMP_W-1:LO_W] <= wdata[HI_W-1:0];
      end
   end

   assign word        = 16'({value, 2'b00});
   assign rd_lo       = word[7:0];
   assign rd_hi       = word[15:8];
   assign unused_lsbs = ^wdata[1:0];

   // R12: no write strobe means the stored value holds
   assert_lim_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi) |=> $stable(value));
endmodule

// File: rtl/thr_alarm_latch.sv
`timescale 1ns/1ps
module thr_alarm_latch
   import thr_regbank_pkg::*;
#(
   parameter int TEMP_W = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fire,
   input  logic [TEMP_W-1:0]           sample,
   input  logic [NLIM-1:0][TEMP_W-1:0] lims,
   input  logic                        clr_we,
   input  logic [NLIM-1:0]             clr_mask,
   output logic [NLIM-1:0]             status
);
   logic [NLIM-1:0] hit;
   logic [NLIM-1:0] kill;

   for (genvar i = 0; i < NLIM; i++) begin : g_cmp
      if (LIM_ABOVE[i]) begin : g_above
         assign hit[i] = $signed(sample) > $signed(lims[i]);
      end else begin : g_below
         assign hit[i] = $signed(sample) < $signed(lims[i]);
      end
   end

   assign kill = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~kill) | (fire ? hit : '0);
   end

   // R7: no new bit appears without a sample
   assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> ((status & ~$past(status)) == '0));
   // R7: bits drop only through a clear write
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((status & $past(status)) == $past(status)));
   // R8: clear mask removes bits when no sample competes
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !fire) |=> ((status & $past(clr_mask)) == '0));
   // R6: a sample above the over threshold sets bit 0
   assert_over_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ($signed(sample) > $signed(lims[0]))) |=> status[0]);
endmodule

// File: rtl/thermal_regbank.sv
`timescale 1ns/1ps
module thermal_regbank
   import thr_regbank_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         TEMP_W      = 11,
   parameter int         MODE_W      = 4,
   parameter logic [1:0] REV_MAJOR   = 2'd1,
   parameter logic [2:0] REV_MINOR   = 3'd2,
   parameter logic [6:0] VENDOR_BANK = 7'h01,
   parameter logic [6:0] VENDOR_ID   = 7'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              samp_valid,
   input  logic [TEMP_W-1:0] samp_temp
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("thermal_regbank: ADDR_W must be at least 6");
   end
   if (MODE_W < 1 || MODE_W > 8) begin : g_bad_mode
      $error("thermal_regbank: MODE_W must lie in 1..8");
   end
   if (VENDOR_ID == 7'h00 || VENDOR_ID == 7'h7F) begin : g_bad_vendor
      $error("thermal_regbank: VENDOR_ID 0x00 and 0x7F are reserved");
   end

   localparam logic [7:0] REV_BYTE = {2'b00, REV_MAJOR, REV_MINOR, 1'b0};
   localparam logic [7:0] BANK_BYTE = with_odd_parity(VENDOR_BANK);
   localparam logic [7:0] VID_BYTE  = with_odd_parity(VENDOR_ID);

   logic [TEMP_W-1:0]           temp_q;
   logic [15:0]                 temp_word;
   logic                        cfg_dis;
   logic [MODE_W-1:0]           mode_q;
   logic                        fire;
   logic                        clr_we;
   logic [NLIM-1:0]             status;
   logic [NLIM-1:0][TEMP_W-1:0] lims;
   logic [7:0]                  lim_rd_lo [NLIM];
   logic [7:0]                  lim_rd_hi [NLIM];

   assign fire   = samp_valid && !cfg_dis;
   assign clr_we = bus_we && (bus_addr == ADDR_W'(A_CLR));

   for (genvar i = 0; i < NLIM; i++) begin : g_lim
      thr_limit_pair #(.TEMP_W(TEMP_W)) u_lim (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (bus_we && (bus_addr == ADDR_W'(A_LIM_BASE + 2*i))),
         .wr_hi (bus_we && (bus_addr == ADDR_W'(A_LIM_BASE + 2*i + 1))),
         .wdata (bus_wdata),
         .value (lims[i]),
         .rd_lo (lim_rd_lo[i]),
         .rd_hi (lim_rd_hi[i])
      );
   end

   thr_alarm_latch #(.TEMP_W(TEMP_W)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .sample   (samp_temp),
      .lims     (lims),
      .clr_we   (clr_we),
      .clr_mask (bus_wdata[NLIM-1:0]),
      .status   (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_q  <= '0;
         cfg_dis <= 1'b0;
         mode_q  <= '0;
      end else begin
         if (fire) temp_q <= samp_temp;
         if (bus_we && bus_addr == ADDR_W'(A_CFG))  cfg_dis <= bus_wdata[0];
         if (bus_we && bus_addr == ADDR_W'(A_MODE)) mode_q  <= bus_wdata[MODE_W-1:0];
      end
   end

   assign temp_word = 16'({temp_q, 2'b00});

   always_comb begin
      bus_rdata = 8'h00;
      unique case (bus_addr)
         ADDR_W'(A_ID0):      bus_rdata = ID0_VAL;
         ADDR_W'(A_ID1):      bus_rdata = ID1_VAL;
         ADDR_W'(A_REV):      bus_rdata = REV_BYTE;
         ADDR_W'(A_VND_BANK): bus_rdata = BANK_BYTE;
         ADDR_W'(A_VND_ID):   bus_rdata = VID_BYTE;
         ADDR_W'(A_CAP):      bus_rdata = CAP_VAL;
         ADDR_W'(A_MODE):     bus_rdata = 8'(mode_q);
         ADDR_W'(A_CFG):      bus_rdata = {7'b0, cfg_dis};
         ADDR_W'(A_TEMP_LO):  bus_rdata = temp_word[7:0];
         ADDR_W'(A_TEMP_HI):  bus_rdata = temp_word[15:8];
         ADDR_W'(A_STAT):     bus_rdata = 8'(status);
         default:             bus_rdata = 8'h00;
      endcase
      for (int i = 0; i < NLIM; i++) begin
         if (bus_addr == ADDR_W'(A_LIM_BASE + 2*i))     bus_rdata = lim_rd_lo[i];
         if (bus_addr == ADDR_W'(A_LIM_BASE + 2*i + 1)) bus_rdata = lim_rd_hi[i];
      end
   end

   // R10: a strobe while disabled leaves the temperature untouched
   assert_dis_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_valid && cfg_dis) |=> $stable(temp_q));
   // R10: a strobe while disabled raises no alarm
   assert_dis_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dis && !clr_we) |=> (status == $past(status)));
   // R4: the even byte of a threshold never shows bits 1:0
   assert_lim_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(A_LIM_BASE)) |-> (bus_rdata[1:0] == 2'b00));
   // R5: a strobe while enabled lands in the temperature register
   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_valid && !cfg_dis) |=> (temp_q == $past(samp_temp)));
endmodule

// File: tb/tb_thermal_regbank.sv
`timescale 1ns/1ps
module tb_thermal_regbank;
   localparam logic [1:0] MAJ  = 2'd1;
   localparam logic [2:0] MIN  = 3'd2;
   localparam logic [6:0] BANK = 7'h04;
   localparam logic [6:0] VID  = 7'h33;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        samp_valid = 1'b0;
   logic [10:0] samp_temp = 11'h000;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   logic signed [10:0] m_lim [4];
   logic signed [10:0] m_temp;
   logic [3:0]         m_stat;
   logic               m_dis;

   always #2 clk = ~clk;

   thermal_regbank #(.REV_MAJOR(MAJ), .REV_MINOR(MIN),
                     .VENDOR_BANK(BANK), .VENDOR_ID(VID)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .samp_valid(samp_valid), .samp_temp(samp_temp));

   function automatic logic [7:0] odd_byte(input logic [6:0] d);
      int ones = 0;
      for (int k = 0; k < 7; k++) ones += d[k];
      return {(ones % 2 == 0) ? 1'b1 : 1'b0, d};
   endfunction
   function automatic logic [7:0] lo_b(input logic [10:0] v);
      return {v[5:0], 2'b00};
   endfunction
   function automatic logic [7:0] hi_b(input logic [10:0] v);
      return {3'b000, v[10:6]};
   endfunction
   function automatic logic [3:0] m_cmp(input logic signed [10:0] t);
      return {t < m_lim[3], t > m_lim[2], t < m_lim[1], t > m_lim[0]};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic samp(input logic [10:0] t);
      @(negedge clk);
      samp_temp = t; samp_valid = 1'b1;
      @(negedge clk);
      samp_valid = 1'b0;
      if (!m_dis) begin
         m_temp = t;
         m_stat = m_stat | m_cmp(t);
      end
   endtask

   task automatic clr(input logic [3:0] mask);
      wr(8'h13, {4'hA, mask});
      m_stat = m_stat & ~mask;
   endtask

   task automatic set_lim(input int idx, input logic signed [10:0] v);
      wr(8'(8'h1C + 2*idx), lo_b(v));
      wr(8'(8'h1D + 2*idx), hi_b(v));
      m_lim[idx] = v;
   endtask

   task automatic chk_state(input string tag);
      rchk({tag, " status"}, 8'h33, {4'h0, m_stat});
      rchk({tag, " temp lo"}, 8'h31, lo_b(m_temp));
      rchk({tag, " temp hi"}, 8'h32, hi_b(m_temp));
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   endtask

   initial begin
      #600000;
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      int r;
      r = $urandom(32'd20240611);
      for (int k = 0; k < 4; k++) m_lim[k] = '0;
      m_temp = '0; m_stat = '0; m_dis = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      chk_state("R1 reset");
      rchk("R1 cfg", 8'h1A, 8'h00);
      rchk("R1 mode", 8'h0B, 8'h00);
      for (int a = 8'h1C; a <= 8'h23; a++) rchk("R1 limit", 8'(a), 8'h00);

      // R2 identity, R3 vendor parity
      rchk("R2 id0", 8'h00, 8'h51);
      rchk("R2 id1", 8'h01, 8'h18);
      rchk("R2 cap", 8'h05, 8'h02);
      rchk("R2 rev", 8'h02, 8'h14);
      rchk("R3 bank", 8'h03, odd_byte(BANK));
      rchk("R3 id", 8'h04, odd_byte(VID));
      rchk("R3 id literal", 8'h04, 8'hB3);

      // R13 unmapped, R9 clear registers
      rchk("R13 0x24", 8'h24, 8'h00);
      rchk("R13 0x40", 8'h40, 8'h00);
      rchk("R13 0xFF", 8'hFF, 8'h00);
      wr(8'h14, 8'hFF);
      rchk("R9 errclr", 8'h14, 8'h00);
      wr(8'h13, 8'hFF);
      rchk("R9 clr", 8'h13, 8'h00);

      // R11 mode register
      wr(8'h0B, 8'hFF);
      rchk("R11 mode ff", 8'h0B, 8'h0F);
      wr(8'h0B, 8'h5A);
      rchk("R11 mode 5a", 8'h0B, 8'h0A);

      // R4 byte field mapping
      wr(8'h1C, 8'hFF);
      wr(8'h1D, 8'hFF);
      rchk("R4 lo ff", 8'h1C, 8'hFC);
      rchk("R4 hi ff", 8'h1D, 8'h1F);

      // directed thresholds: 80, -10, 100, -40 degrees
      set_lim(0, 11'sd320);
      set_lim(1, -11'sd40);
      set_lim(2, 11'sd400);
      set_lim(3, -11'sd160);
      rchk("R4 over lo", 8'h1C, 8'h00);
      rchk("R4 over hi", 8'h1D, 8'h05);
      rchk("R4 lcrit lo", 8'h22, lo_b(-11'sd160));
      rchk("R4 lcrit hi", 8'h23, 8'h1D);

      // R6 strict boundaries, R7 latching, R8 partial clear
      samp(11'sd320);  chk_state("R6 equal over");
      rchk("R6 literal 0", 8'h33, 8'h00);
      samp(11'sd321);  chk_state("R6 above over");
      rchk("R6 literal 1", 8'h33, 8'h01);
      samp(11'sd0);    chk_state("R7 held");
      clr(4'h1);       chk_state("R8 clear bit0");
      samp(11'sd401);  chk_state("R6 above crit");
      clr(4'h4);       chk_state("R8 partial");
      rchk("R8 literal", 8'h33, 8'h01);
      clr(4'hF);
      samp(-11'sd40);  chk_state("R6 equal under");
      samp(-11'sd41);  chk_state("R6 below under");
      samp(-11'sd161); chk_state("R6 below lcrit");
      rchk("R6 literal a", 8'h33, 8'h0A);
      clr(4'hF);
      samp(11'h400);   chk_state("R5 min code");
      rchk("R5 min hi", 8'h32, 8'h10);
      clr(4'hF);
      samp(11'h3FF);   chk_state("R5 max code");
      rchk("R5 max lo", 8'h31, 8'hFC);
      clr(4'hF);

      // R8 clear and set in the same cycle
      @(negedge clk);
      bus_addr = 8'h13; bus_wdata = 8'h0F; bus_we = 1'b1;
      samp_temp = 11'sd500; samp_valid = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; samp_valid = 1'b0;
      m_temp = 11'sd500; m_stat = 4'h5;
      chk_state("R8 set wins");
      clr(4'hF);

      // R10 disable
      wr(8'h1A, 8'hFF); m_dis = 1'b1;
      rchk("R10 cfg", 8'h1A, 8'h01);
      samp(11'sd1000); chk_state("R10 disabled");
      samp(-11'sd1000); chk_state("R10 disabled low");
      wr(8'h1A, 8'h00); m_dis = 1'b0;
      rchk("R10 cfg off", 8'h1A, 8'h00);

      // R12 writes to read-only addresses
      wr(8'h33, 8'hFF); wr(8'h31, 8'hAA); wr(8'h32, 8'hAA);
      chk_state("R12 ro temp/status");
      wr(8'h00, 8'hAA); rchk("R12 id0", 8'h00, 8'h51);
      wr(8'h05, 8'hFF); rchk("R12 cap", 8'h05, 8'h02);
      wr(8'h24, 8'h55); rchk("R12 0x24", 8'h24, 8'h00);
      rchk("R12 lcrit hi", 8'h23, hi_b(m_lim[3]));
      wr(8'h1B, 8'h55); rchk("R12 0x1B", 8'h1B, 8'h00);
      rchk("R12 cfg", 8'h1A, 8'h00);

      // random mix
      for (int it = 0; it < 600; it++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 3) begin
            int idx; logic [7:0] b; bit hi;
            idx = $urandom_range(0, 3); b = 8'($urandom); hi = 1'($urandom);
            wr(8'(8'h1C + 2*idx + int'(hi)), b);
            if (hi) m_lim[idx][10:6] = b[4:0];
            else    m_lim[idx][5:0]  = b[7:2];
            rchk("R4 random lo", 8'(8'h1C + 2*idx), lo_b(m_lim[idx]));
            rchk("R4 random hi", 8'(8'h1D + 2*idx), hi_b(m_lim[idx]));
         end else if (op < 7) begin
            samp(11'($urandom));
            chk_state("R6 random");
         end else if (op < 9) begin
            clr(4'($urandom));
            chk_state("R8 random");
         end else begin
            logic [7:0] b;
            b = 8'($urandom);
            b[0] = ($urandom_range(0, 3) == 0);
            wr(8'h1A, b); m_dis = b[0];
            rchk("R10 random cfg", 8'h1A, {7'b0, m_dis});
         end
      end

      done = 1;
      finish_run();
   end
endmodule